// File: doc/BRIEF.md
# Set-Based Programmable Interrupt Prioritizer

This block picks one interrupt out of forty-eight request lines and reports its vector number. The lines come in six sets of eight. Set 0 and set 1 are the mixed sets, and sets 2 to 5 are the internal sets. Each set has a 32-bit ordering word that software writes. The word says which of the set's eight sources takes each of eight relative positions. Each set also has a placement select bit. In grouped placement, the set's eight positions map onto one run of neighbouring levels in a single global order of up to 127 levels. In spread placement, they map onto levels that are scattered and interleaved with the other sets.

On every clock the block finds the pending, unmasked request that sits at the numerically lowest global level. It registers that source's fixed vector number together with a valid flag. Software reaches the ordering words and the placement bits through a small synchronous write port and a combinational read port. A configuration-error output shows when an ordering word names the same source in two positions.

Top module: `irq_set_prioritizer`

## Requirements
- R1: After reset every ordering word reads 0x05309770 (position n holds source n), the placement register reads 0 (all sets grouped), and vec_valid, vec_out and cfg_err are 0.
- R2: Ordering word fields are 3 bits wide. Position 0 is in bits 31:29, position 1 in 28:26, position 2 in 25:23, position 3 in 22:20, position 4 in 15:13, position 5 in 12:10, position 6 in 9:7 and position 7 in 6:4. Bits 19:16 and 3:0 are not stored and read as zero. A write to address s (0 to 5) sets the word of set s.
- R3: A source i of set s takes position p when field p of word s holds the value i. The source's level comes from that position, not from its index.
- R4: In grouped placement, position p of set 0 is at level 2+p. Position p of set s (s ≥ 1) is at level 88+8(s-1)+p.
- R5: In spread placement, position p of set 0 is at level 1+10p. Position p of set s (s ≥ 1) is at level 11+10p+s.
- R6: Bit s of the placement register (address 6, bits 5:0) selects spread placement for set s when 1 and grouped placement when 0. Only the selected placement's levels apply. The register changes only on a write to address 6. Reads of address 7 return 0.
- R7: Among the pending, unmasked, placed sources, the one at the lowest level wins.
- R8: The vector for global source g = 8s+i is (37·g+5) mod 128. It depends only on g and never on the position the source holds.
- R9: A source whose irq_mask bit is 1 is never selected. vec_valid only rises when some request was pending and unmasked one cycle earlier.
- R10: If a word names a source in more than one position, the source takes the lowest of those positions. A source named in no position is never selected. cfg_err is 1 while any set's word has a duplicate.
- R11: vec_out and vec_valid are registered and reflect the requests, masks and configuration present at the previous clock edge. When nothing is eligible, vec_valid is 0 and vec_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 48 | Request lines; bit 8s+i is source i of set s |
| irq_mask | input | 48 | Per-source mask; 1 blocks the source |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | 0 to 5 ordering words, 6 placement register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data at cfg_addr |
| cfg_err | output | 1 | Some ordering word holds a duplicate field |
| vec_valid | output | 1 | A winning request is reported |
| vec_out | output | 7 | Vector number of the winner |

## Verification
A corrupted ordering word or placement bit does not stay hidden. Within one clock it moves the winner, and the wrong vector_out shows up as soon as two requests from the affected sets compete. A bad stored word also shows directly on cfg_rdata and on cfg_err in the same cycle. The reference model is compared on every clock against dense random request and mask patterns under several orderings and placement mixes. Because of this, a wrong level table entry or a wrong lowest-position rule is exposed within a few cycles, not only in chosen corner cases.

// File: rtl/irqp_pkg.sv
`timescale 1ns/1ps
package irqp_pkg;

   localparam int LVL_W   = 7;
   localparam int WORD_W  = 32;
   localparam int FIELD_W = 3;
   localparam int VEC_W   = 7;

   // bit offset of position p inside an ordering word (gap at 19:16)
   function automatic int field_lsb(input int p);
      return (p < 4) ? (29 - 3 * p) : (13 - 3 * (p - 4));
   endfunction

   // contiguous run per set
   function automatic logic [LVL_W-1:0] grouped_level(input int s, input int p);
      int v;
      v = (s == 0) ? (2 + p) : (88 + 8 * (s - 1) + p);
      return LVL_W'(v);
   endfunction

   // interleaved across sets, blocks of ten levels
   function automatic logic [LVL_W-1:0] spread_level(input int s, input int p);
      int v;
      v = (s == 0) ? (1 + 10 * p) : (11 + 10 * p + s);
      return LVL_W'(v);
   endfunction

   function automatic logic [VEC_W-1:0] vector_of(input int g);
      return VEC_W'((37 * g + 5) % 128);
   endfunction

   function automatic logic [WORD_W-1:0] identity_word(input int n_pos);
      logic [WORD_W-1:0] w;
      w = '0;
      for (int p = 0; p < n_pos; p++) w[field_lsb(p) +: FIELD_W] = FIELD_W'(p);
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] stored_bits(input int n_pos);
      logic [WORD_W-1:0] w;
      w = '0;
      for (int p = 0; p < n_pos; p++) w[field_lsb(p) +: FIELD_W] = '1;
      return w;
   endfunction

endpackage

// File: rtl/irqp_set_map.sv
`timescale 1ns/1ps
module irqp_set_map
   import irqp_pkg::*;
#(
   parameter int SET_IDX  = 0,
   parameter int SET_SIZE = 8
) (
   input  logic [WORD_W-1:0]                 prio_word,
   input  logic                              spread_sel,
   output logic [SET_SIZE-1:0]               src_placed,
   output logic [SET_SIZE-1:0][LVL_W-1:0]    src_level,
   output logic                              dup_err
);

   logic [SET_SIZE-1:0][FIELD_W-1:0] pos_src;
   logic [SET_SIZE-1:0][LVL_W-1:0]   lvl_grp;
   logic [SET_SIZE-1:0][LVL_W-1:0]   lvl_spr;

   for (genvar p = 0; p < SET_SIZE; p++) begin : g_pos
      assign pos_src[p] = prio_word[field_lsb(p) +: FIELD_W];
      assign lvl_grp[p] = grouped_level(SET_IDX, p);
      assign lvl_spr[p] = spread_level(SET_IDX, p);
   end

   // descending scan so the lowest naming position is the one kept
   always_comb begin
      for (int i = 0; i < SET_SIZE; i++) begin
         src_placed[i] = 1'b0;
         src_level[i]  = '0;
         for (int p = SET_SIZE - 1; p >= 0; p--) begin
            if (pos_src[p] == FIELD_W'(i)) begin
               src_placed[i] = 1'b1;
               src_level[i]  = spread_sel ? lvl_spr[p] : lvl_grp[p];
            end
         end
      end
   end

   // eight fields over eight sources: a duplicate leaves some source unnamed
   assign dup_err = ~&src_placed;

endmodule

// File: rtl/irqp_min_select.sv
`timescale 1ns/1ps
module irqp_min_select
   import irqp_pkg::*;
#(
   parameter  int N     = 48,
   localparam int IDX_W = $clog2(N)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N-1:0]              active,
   input  logic [N-1:0][LVL_W-1:0]   level,
   output logic                      win_valid,
   output logic [IDX_W-1:0]          win_idx
);

   logic [LVL_W-1:0] best_lvl;

   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      best_lvl  = '1;
      for (int i = 0; i < N; i++) begin
         if (active[i] && (!win_valid || level[i] < best_lvl)) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(i);
            best_lvl  = level[i];
         end
      end
   end

   // R7: the chosen index is an eligible source
   p_win_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> active[win_idx]);

   // R7: nothing eligible means no winner
   p_none_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active == '0) |-> !win_valid);

endmodule

// File: rtl/irq_set_prioritizer.sv
`timescale 1ns/1ps
module irq_set_prioritizer
   import irqp_pkg::*;
#(
   parameter  int NUM_SETS = 6,
   parameter  int SET_SIZE = 8,
   parameter  int ADDR_W   = 3,
   localparam int N_SRC    = NUM_SETS * SET_SIZE,
   localparam int IDX_W    = $clog2(N_SRC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SRC-1:0]     irq_req,
   input  logic [N_SRC-1:0]     irq_mask,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [WORD_W-1:0]    cfg_wdata,
   output logic [WORD_W-1:0]    cfg_rdata,
   output logic                 cfg_err,
   output logic                 vec_valid,
   output logic [VEC_W-1:0]     vec_out
);

   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(6);
   localparam logic [WORD_W-1:0] RST_WORD  = identity_word(SET_SIZE);
   localparam logic [WORD_W-1:0] KEEP_MASK = stored_bits(SET_SIZE);

   if (SET_SIZE != 8) begin : g_bad_size
      $error("irq_set_prioritizer: ordering word layout needs SET_SIZE of 8");
   end
   if (NUM_SETS < 1 || NUM_SETS > 6) begin : g_bad_sets
      $error("irq_set_prioritizer: level table covers one to six sets");
   end
   if ((1 << ADDR_W) <= 6) begin : g_bad_addr
      $error("irq_set_prioritizer: address too narrow for placement register");
   end

   logic [NUM_SETS-1:0][WORD_W-1:0]          prio_q;
   logic [NUM_SETS-1:0]                      mode_q;
   logic [N_SRC-1:0]                         placed;
   logic [N_SRC-1:0][LVL_W-1:0]              level;
   logic [NUM_SETS-1:0]                      set_dup;
   logic [N_SRC-1:0]                         active;
   logic                                     win_valid;
   logic [IDX_W-1:0]                         win_idx;

   // configuration storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) prio_q[s] <= RST_WORD;
         mode_q <= '0;
      end else if (cfg_we) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            if (cfg_addr == ADDR_W'(s)) prio_q[s] <= cfg_wdata & KEEP_MASK;
         end
         if (cfg_addr == MODE_ADDR) mode_q <= cfg_wdata[NUM_SETS-1:0];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (cfg_addr == ADDR_W'(s)) cfg_rdata = prio_q[s];
      end
      if (cfg_addr == MODE_ADDR) cfg_rdata = WORD_W'(mode_q);
   end

   // per-set level decode
   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      irqp_set_map #(
         .SET_IDX  (s),
         .SET_SIZE (SET_SIZE)
      ) u_map (
         .prio_word  (prio_q[s]),
         .spread_sel (mode_q[s]),
         .src_placed (placed[s*SET_SIZE +: SET_SIZE]),
         .src_level  (level[s*SET_SIZE +: SET_SIZE]),
         .dup_err    (set_dup[s])
      );
   end

   assign active  = irq_req & ~irq_mask & placed;
   assign cfg_err = |set_dup;

   irqp_min_select #(
      .N (N_SRC)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .level     (level),
      .win_valid (win_valid),
      .win_idx   (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         vec_valid <= win_valid;
         vec_out   <= win_valid ? vector_of(int'(win_idx)) : '0;
      end
   end

   // R11: no eligible request at an edge leaves valid low after it
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(irq_req & ~irq_mask)) |=> !vec_valid);

   // R9: a new valid needs an unmasked request one edge before
   p_rise_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_valid) |-> $past(|(irq_req & ~irq_mask)));

   // R2: unstored bit ranges of an ordering word read zero
   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr < ADDR_W'(NUM_SETS)) |-> (cfg_rdata[19:16] == 4'd0 && cfg_rdata[3:0] == 4'd0));

   // R6: placement bits move only on a write to their address
   p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we || cfg_addr != MODE_ADDR) |=> $stable(mode_q));

endmodule

// File: tb/irq_set_prioritizer_tb.sv
`timescale 1ns/1ps
module irq_set_prioritizer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] irq_req = '0;
   logic [47:0] irq_mask = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cfg_err;
   logic        vec_valid;
   logic [6:0]  vec_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // reference state
   int model_word [6];
   int model_mode;

   always #10 clk = ~clk;

   irq_set_prioritizer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .irq_mask  (irq_mask),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cfg_err   (cfg_err),
      .vec_valid (vec_valid),
      .vec_out   (vec_out)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int lsb_of(input int p);
      if (p < 4) return 29 - 3 * p;
      return 13 - 3 * (p - 4);
   endfunction

   function automatic int field(input int w, input int p);
      return (w >> lsb_of(p)) & 7;
   endfunction

   function automatic int perm_word(input int a, input int b);
      int w = 0;
      for (int p = 0; p < 8; p++) w |= ((a * p + b) % 8) << lsb_of(p);
      return w;
   endfunction

   function automatic bit model_err();
      for (int s = 0; s < 6; s++)
         for (int i = 0; i < 8; i++) begin
            bit seen = 0;
            for (int p = 0; p < 8; p++) if (field(model_word[s], p) == i) seen = 1;
            if (!seen) return 1;
         end
      return 0;
   endfunction

   task automatic model_out(input logic [47:0] rq, input logic [47:0] mk,
                            output bit v, output int vec);
      int best = 1000;
      v = 0; vec = 0;
      for (int s = 0; s < 6; s++)
         for (int i = 0; i < 8; i++) begin
            int g = 8 * s + i;
            int pos = -1;
            int lvl;
            if (!rq[g] || mk[g]) continue;
            for (int p = 7; p >= 0; p--) if (field(model_word[s], p) == i) pos = p;
            if (pos < 0) continue;
            if ((model_mode >> s) & 1) lvl = (s == 0) ? 1 + 10 * pos : 11 + 10 * pos + s;
            else                       lvl = (s == 0) ? 2 + pos : 88 + 8 * (s - 1) + pos;
            if (lvl < best) begin
               best = lvl; v = 1; vec = (37 * g + 5) % 128;
            end
         end
   endtask

   task automatic model_write(input int a, input logic [31:0] d);
      if (a < 6) model_word[a] = int'(d & 32'hFFF0_FFF0);
      else if (a == 6) model_mode = int'(d[5:0]);
   endtask

   // one clock: drive at negedge, compare 5 ns after the next posedge
   task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [47:0] rq, input logic [47:0] mk, input string tag);
      bit ev;
      int evec;
      cfg_we = we; cfg_addr = a; cfg_wdata = d; irq_req = rq; irq_mask = mk;
      model_out(rq, mk, ev, evec);
      if (we) model_write(int'(a), d);
      @(posedge clk); #5;
      check(vec_valid == ev, tag, "vec_valid", vec_valid, ev);
      check(vec_out == 7'(evec), tag, "vec_out", vec_out, evec);
      check(cfg_err == model_err(), "R10", "cfg_err", cfg_err, model_err());
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      cfg_we = 1'b0; cfg_addr = a; #1;
      check(cfg_rdata == exp, tag, "cfg_rdata", cfg_rdata, exp);
   endtask

   function automatic logic [47:0] rnd48(input int density);
      logic [47:0] r = {$urandom, $urandom};
      for (int k = 0; k < density; k++) r &= {$urandom, $urandom};
      return r;
   endfunction

   task automatic burst(input int n, input int density, input bit use_mask, input string tag);
      for (int k = 0; k < n; k++)
         cyc(1'b0, 3'd0, '0, rnd48(density), use_mask ? rnd48(0) : 48'd0, tag);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fails++;
         $display("FAIL R11 watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 6; s++) model_word[s] = 32'h0530_9770;
      model_mode = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(vec_valid == 1'b0, "R1", "vec_valid in reset", vec_valid, 0);
      check(cfg_err == 1'b0, "R1", "cfg_err in reset", cfg_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(vec_out == 7'd0, "R1", "vec_out after reset", vec_out, 0);
      for (int s = 0; s < 6; s++) rd(3'(s), 32'h0530_9770, "R1");
      rd(3'd6, 32'd0, "R1");
      rd(3'd7, 32'd0, "R6");

      // R2: stored bits only, duplicates flagged
      cyc(1'b1, 3'd2, 32'hFFFF_FFFF, '0, '0, "R2");
      rd(3'd2, 32'hFFF0_FFF0, "R2");
      check(cfg_err == 1'b1, "R10", "cfg_err all-seven word", cfg_err, 1);
      cyc(1'b1, 3'd2, 32'h0530_9770, '0, '0, "R2");
      rd(3'd2, 32'h0530_9770, "R2");

      // R4 R8: identity order, all grouped
      burst(60, 1, 1'b0, "R4");
      burst(40, 3, 1'b0, "R7");
      // single sources: vector depends on source only
      for (int g = 0; g < 48; g++) cyc(1'b0, 3'd0, '0, 48'd1 << g, '0, "R8");

      // R5: all spread
      cyc(1'b1, 3'd6, 32'h3F, rnd48(2), '0, "R6");
      rd(3'd6, 32'h3F, "R6");
      burst(60, 2, 1'b0, "R5");
      // R6: mixed placement
      cyc(1'b1, 3'd6, 32'h15, rnd48(2), '0, "R6");
      burst(60, 2, 1'b0, "R6");
      cyc(1'b1, 3'd6, 32'h2A, rnd48(2), '0, "R6");
      burst(40, 2, 1'b0, "R6");

      // R3: remapped positions, each set a different permutation
      for (int s = 0; s < 6; s++)
         cyc(1'b1, 3'(s), 32'(perm_word(2 * s + 3, s + 1)), rnd48(2), '0, "R3");
      for (int s = 0; s < 6; s++) rd(3'(s), 32'(perm_word(2 * s + 3, s + 1)), "R3");
      burst(60, 2, 1'b0, "R3");
      // same source repositioned, vector unchanged
      for (int g = 0; g < 48; g += 7) cyc(1'b0, 3'd0, '0, 48'd1 << g, '0, "R8");
      cyc(1'b1, 3'd6, 32'h00, rnd48(2), '0, "R3");
      burst(40, 2, 1'b0, "R3");

      // R9: masking
      burst(80, 1, 1'b1, "R9");
      cyc(1'b0, 3'd0, '0, {48{1'b1}}, {48{1'b1}}, "R9");
      cyc(1'b0, 3'd0, '0, {48{1'b1}}, {47{1'b1}} << 1, "R9");

      // R10: duplicates, lowest position kept, unnamed source never wins
      cyc(1'b1, 3'd0, 32'h2530_9770, rnd48(1), '0, "R10");
      check(cfg_err == 1'b1, "R10", "cfg_err duplicate", cfg_err, 1);
      cyc(1'b0, 3'd0, '0, 48'h01, '0, "R10");
      cyc(1'b0, 3'd0, '0, 48'h03, '0, "R10");
      burst(40, 1, 1'b0, "R10");
      cyc(1'b1, 3'd6, 32'h01, '0, '0, "R10");
      burst(30, 1, 1'b0, "R10");
      cyc(1'b1, 3'd0, 32'h0530_9770, '0, '0, "R10");
      check(cfg_err == 1'b0, "R10", "cfg_err cleared", cfg_err, 0);

      // R11: idle and one-cycle update
      cyc(1'b0, 3'd0, '0, '0, '0, "R11");
      cyc(1'b0, 3'd0, '0, 48'h8000_0000_0000, '0, "R11");
      cyc(1'b0, 3'd0, '0, '0, '0, "R11");
      burst(30, 4, 1'b1, "R11");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule